// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block samples a 32-bit word of digital inputs and turns changes on the low 16 of them into one interrupt request. Software reads the whole input word, selects per channel which inputs take part and with which polarity, and picks one of two ways of combining them. In the edge-combining mode, any selected channel that makes its chosen transition raises an event. In the level-combining mode, one event is raised when every selected channel sits at its chosen level at the same time. After such an event, the level-combining logic stays quiet until a selected input changes level again.

Events are held in a 16-bit cause register that clears itself when it is read. The interrupt line stays high while that register has an unread bit and interrupts are enabled. A register bus with one-cycle accesses carries all of this. It has a write strobe, a read strobe, a word address and 32-bit data, and read data is combinational from the address. The bus has no back-pressure: every access completes in the cycle its strobe is high. The clear-on-read side effect takes place at the clock edge that ends that cycle.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset the interrupt line is low, and the selection, control and cause registers all read zero.
- R2: A read at offset 0x00 returns all 32 inputs after a two-flop synchronizer. A change on an input shows up at the second rising edge after it.
- R3: Offset 0x04 is the high/rising selection register and offset 0x08 is the low/falling selection register. Each holds 16 bits, bit n for channel n, and its bits 31..16 read as zero.
- R4: In edge mode, a rising edge on a channel selected at 0x04 sets that channel's bit in the cause register. The interrupt line rises after the third rising clock edge that follows the input change.
- R5: In edge mode, a falling edge on a channel selected at 0x08 sets that channel's bit in the cause register.
- R6: Channels 16 to 31, unselected channels, and transitions of the wrong polarity never set a cause bit.
- R7: In level mode, when every channel selected in either register is at its chosen level (high for 0x04, low for 0x08), one event is raised and the cause register receives the whole selected set.
- R8: After a level-mode event, no further event is raised until a selected channel changes level and the full condition is met again. Changes on unselected channels do not release it.
- R9: A read at offset 0x0C returns the cause bits in bits 15..0 and clears them. The interrupt line then falls unless a new event arrives.
- R10: An event that is detected in the same cycle as the cause read is kept in the cause register, while the bits that were read are cleared.
- R11: The control register is at offset 0x10. Bit 2 is the enable bit. Bit 1 selects the mode, with 0 for edge and 1 for level. Bit 0 reads as a pending flag that is set while the cause register is non-zero. A write with bit 2 clear disables events and leaves the stored mode unchanged. While events are disabled, no cause bit is set.
- R12: The interrupt line is high exactly when the enable bit is 1 and the cause register is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 32 | Raw digital inputs, asynchronous to clk |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; clears the cause register at 0x0C |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle and that each read of offset 0x0C is a deliberate one-cycle pulse, because a held strobe would clear the cause register again on every cycle. They also assume din changes no more than once per synchronizer delay on the channels under test, so that every edge is seen as one separate transition. The bench drives din and the bus strobes only on falling clock edges. It raises each strobe for exactly one cycle and waits for the synchronizer and detection latency before it looks at the results. It reconfigures the block only after events are disabled and the cause register has been drained.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_RAW   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_SELHI = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SELLO = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h10;

  localparam int CTRL_EN_BIT   = 2;
  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_PEND_BIT = 0;

  typedef enum logic {
    COMB_EDGE  = 1'b0,
    COMB_LEVEL = 1'b1
  } comb_mode_e;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cos_detect.sv
module cos_detect
  import cos_pkg::*;
#(
  parameter int N = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [N-1:0] smp,
  input  logic       en,
  input  comb_mode_e mode,
  input  logic [N-1:0] sel_hi,
  input  logic [N-1:0] sel_lo,
  output logic [N-1:0] hit,
  output logic       level_fire
);
  logic [N-1:0] prev;
  logic [N-1:0] rise, fall, chg, sel, ok, edge_hit;
  logic         cond, level_on, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= smp;
  end

  assign rise     = smp & ~prev;
  assign fall     = ~smp & prev;
  assign chg      = smp ^ prev;
  assign edge_hit = (rise & sel_hi) | (fall & sel_lo);

  assign sel  = sel_hi | sel_lo;
  assign ok   = (smp & sel_hi) | (~smp & sel_lo);
  assign cond = (|sel) && ((ok & sel) == sel);

  assign level_on   = en && (mode == COMB_LEVEL);
  assign level_fire = level_on && cond && armed;

  // Re-arm only on a level change of a selected channel after firing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              armed <= 1'b1;
    else if (!level_on)      armed <= 1'b1;
    else if (level_fire)     armed <= 1'b0;
    else if (|(chg & sel))   armed <= 1'b1;
  end

  always_comb begin
    hit = '0;
    if (en) begin
      if (mode == COMB_EDGE) hit = edge_hit;
      else if (level_fire)   hit = sel;
    end
  end
endmodule

// File: rtl/cos_status.sv
module cos_status #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         rd_clr,
  output logic [N-1:0] cause,
  output logic         pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cause <= '0;
    else if (rd_clr) cause <= hit;
    else             cause <= cause | hit;
  end

  assign pending = |cause;
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int IRQ_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int PAD_W = DATA_W - IRQ_W;

  logic [DATA_W-1:0] din_s;
  logic [IRQ_W-1:0]  sel_hi, sel_lo, hit_w, cause_q;
  logic              ctrl_en, pend, rd_clr, and_fire;
  comb_mode_e        ctrl_mode;

  cos_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(din_s)
  );

  cos_detect #(.N(IRQ_W)) u_det (
    .clk(clk), .rst_n(rst_n), .smp(din_s[IRQ_W-1:0]),
    .en(ctrl_en), .mode(ctrl_mode), .sel_hi(sel_hi), .sel_lo(sel_lo),
    .hit(hit_w), .level_fire(and_fire)
  );

  assign rd_clr = bus_rd && (bus_addr == OFS_CAUSE);

  cos_status #(.N(IRQ_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .rd_clr(rd_clr),
    .cause(cause_q), .pending(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hi    <= '0;
      sel_lo    <= '0;
      ctrl_en   <= 1'b0;
      ctrl_mode <= COMB_EDGE;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_SELHI: sel_hi <= bus_wdata[IRQ_W-1:0];
        OFS_SELLO: sel_lo <= bus_wdata[IRQ_W-1:0];
        OFS_CTRL: begin
          ctrl_en <= bus_wdata[CTRL_EN_BIT];
          // mode is only taken when enabling, so disable keeps it
          if (bus_wdata[CTRL_EN_BIT])
            ctrl_mode <= comb_mode_e'(bus_wdata[CTRL_MODE_BIT]);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_RAW:   bus_rdata = din_s;
      OFS_SELHI: bus_rdata = {{PAD_W{1'b0}}, sel_hi};
      OFS_SELLO: bus_rdata = {{PAD_W{1'b0}}, sel_lo};
      OFS_CAUSE: bus_rdata = {{PAD_W{1'b0}}, cause_q};
      OFS_CTRL: begin
        bus_rdata[CTRL_EN_BIT]   = ctrl_en;
        bus_rdata[CTRL_MODE_BIT] = ctrl_mode;
        bus_rdata[CTRL_PEND_BIT] = pend;
      end
      default: ;
    endcase
  end

  assign irq = ctrl_en && pend;
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk #(
  parameter int IRQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             ctrl_en,
  input logic [IRQ_W-1:0] cause_q,
  input logic [IRQ_W-1:0] hit_w,
  input logic             rd_clr,
  input logic             and_fire
);
  assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_en);

  assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && hit_w == '0) |=> (cause_q == '0));

  assert_irq_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && hit_w == '0) |=> !irq);

  assert_keep_new_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_w) |=> ((cause_q & $past(hit_w)) == $past(hit_w)));

  assert_hold_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && hit_w == '0) |=> $stable(cause_q));

  assert_level_single_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    and_fire |=> !and_fire);
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.IRQ_W(IRQ_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ctrl_en(ctrl_en),
  .cause_q(cause_q), .hit_w(hit_w), .rd_clr(rd_clr), .and_fire(and_fire)
);

// File: tb/cos_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cos_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] din = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cos_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic cleanup();
    logic [31:0] v;
    wr(5'h10, 32'h0);
    @(negedge clk); din = '0;
    settle();
    rd(5'h0C, v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(5'h04, v); check("R1 sel hi", v, 32'h0);
    rd(5'h08, v); check("R1 sel lo", v, 32'h0);
    rd(5'h10, v); check("R1 ctrl", v, 32'h0);
    rd(5'h0C, v); check("R1 cause", v, 32'h0);
  endtask

  task automatic t_raw();
    logic [31:0] v;
    @(negedge clk); din = 32'hA5C3_0F81;
    @(negedge clk); bus_addr = 5'h00;
    #1 check("R2 one edge", bus_rdata, 32'h0);
    @(negedge clk); #1 check("R2 two edges", bus_rdata, 32'hA5C3_0F81);
    din = 32'h0;
    settle();
    rd(5'h00, v); check("R2 back to zero", v, 32'h0);
  endtask

  task automatic t_sel_regs();
    logic [31:0] v;
    wr(5'h04, 32'hFFFF_1234); rd(5'h04, v); check("R3 sel hi", v, 32'h0000_1234);
    wr(5'h08, 32'h8001_ABCD); rd(5'h08, v); check("R3 sel lo", v, 32'h0000_ABCD);
  endtask

  task automatic t_edge_rise();
    logic [31:0] v;
    wr(5'h04, 32'h0000_0001); wr(5'h08, 32'h0);
    wr(5'h10, 32'h4);
    @(negedge clk); din = 32'h1;
    @(negedge clk); @(negedge clk);
    check("R4 no irq before latency", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R4 irq after third edge", {31'b0, irq}, 32'h1);
    check("R12 irq high", {31'b0, irq}, 32'h1);
    rd(5'h10, v); check("R11 pending flag", v, 32'h5);
    rd(5'h0C, v); check("R9 cause value", v, 32'h1);
    check("R9 irq dropped", {31'b0, irq}, 32'h0);
    rd(5'h0C, v); check("R9 cleared", v, 32'h0);
    @(negedge clk); din = 32'h0;   // falling edge on rise-only channel
    settle();
    rd(5'h0C, v); check("R6 wrong polarity", v, 32'h0);
    cleanup();
  endtask

  task automatic t_edge_fall();
    logic [31:0] v;
    @(negedge clk); din = 32'h0000_0040;
    settle();
    wr(5'h04, 32'h0); wr(5'h08, 32'h0000_0040);
    wr(5'h10, 32'h4);
    @(negedge clk); din = 32'h0;
    settle();
    check("R5 irq", {31'b0, irq}, 32'h1);
    rd(5'h0C, v); check("R5 cause", v, 32'h0000_0040);
    cleanup();
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(5'h04, 32'h0000_0001); wr(5'h08, 32'h0000_0001);
    wr(5'h10, 32'h4);
    @(negedge clk); din = 32'hFFFF_0010;
    settle();
    @(negedge clk); din = 32'h0;
    settle();
    check("R6 irq low", {31'b0, irq}, 32'h0);
    rd(5'h0C, v); check("R6 cause", v, 32'h0);
    wr(5'h10, 32'h0);
    @(negedge clk); din = 32'h1;
    settle();
    rd(5'h0C, v); check("R11 disabled no event", v, 32'h0);
    check("R12 irq low disabled", {31'b0, irq}, 32'h0);
    cleanup();
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(5'h04, 32'h0000_0001); wr(5'h08, 32'h0000_0002);
    wr(5'h10, 32'h6);
    settle();
    check("R7 no fire while ch0 low", {31'b0, irq}, 32'h0);
    @(negedge clk); din = 32'h1;
    settle();
    check("R7 irq", {31'b0, irq}, 32'h1);
    rd(5'h0C, v); check("R7 cause set", v, 32'h3);
    settle();
    rd(5'h0C, v); check("R8 no refire", v, 32'h0);
    @(negedge clk); din = 32'h21;  // unselected channel 5
    settle();
    @(negedge clk); din = 32'h01;
    settle();
    rd(5'h0C, v); check("R8 unselected no release", v, 32'h0);
    @(negedge clk); din = 32'h0;
    settle();
    rd(5'h0C, v); check("R8 condition broken", v, 32'h0);
    @(negedge clk); din = 32'h1;
    settle();
    rd(5'h0C, v); check("R8 refire after change", v, 32'h3);
    cleanup();
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    wr(5'h04, 32'h0000_000C); wr(5'h08, 32'h0);
    wr(5'h10, 32'h4);
    @(negedge clk); din = 32'h4;
    settle();
    @(negedge clk); din = 32'hC;   // ch3 edge latches at third edge
    @(negedge clk);
    rd(5'h0C, v);                   // read cycle ends on that edge
    check("R10 read old bit", v, 32'h4);
    check("R10 irq kept", {31'b0, irq}, 32'h1);
    rd(5'h0C, v); check("R10 new bit kept", v, 32'h8);
    cleanup();
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(5'h04, 32'h0); wr(5'h08, 32'h0);
    wr(5'h10, 32'h6); rd(5'h10, v); check("R11 ctrl level", v, 32'h6);
    wr(5'h10, 32'h0); rd(5'h10, v); check("R11 mode kept on disable", v, 32'h2);
    wr(5'h10, 32'h4); rd(5'h10, v); check("R11 edge mode", v, 32'h4);
    cleanup();
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw();
    t_sel_regs();
    t_edge_rise();
    t_edge_fall();
    t_ignored();
    t_level();
    t_same_cycle();
    t_ctrl();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule